// File: doc/BRIEF.md
# Two-Slot ECC Error Capture Log

This block keeps a record of ECC errors found on memory read data. It sits next to an ECC checker and receives error events from one or more checker lanes. Each event carries a valid strobe, a flag that marks the error as uncorrectable, an 8-bit syndrome, and the index of the chunk within a four-chunk burst that is returned in critical-chunk order. The location of the failing module is supplied once per cycle: card, bank, row, and the starting quadword (effective address bits [4:3]). Each captured error fills a 16-bit log word and an 8-bit location byte in one of two slots. The earliest error goes to slot 0 and the next one to slot 1.

Software reaches the slots through a small register port. Reads are combinational. A write updates a single register, and writing zero to a slot's two flag bits frees that slot. The slots are sticky: a cold reset clears them, and a warm reset leaves them unchanged. A read-only overflow bit reports errors that arrived while both slots were full. That bit is cleared by either reset. The block does not compute ECC, does not correct data, does not decode addresses and does not raise interrupts.

Top module: `ecc_err_log`

## Requirements
- R1: After a cold reset (rst_cold_n low at a clock edge), every log word, every location byte and the status register read zero.
- R2: Each error event goes to the lowest-numbered free slot. Starting from empty slots, the first error lands in slot 0 and the second in slot 1. A slot is free when both of its flag bits (bits 1:0 of its log word) are zero.
- R3: A captured log word holds the syndrome in bits 15:8, zeros in bits 7:4, the chunk number in bits 3:2, 1 in bit 1 for an uncorrectable error, and 1 in bit 0 for a correctable error. A capture sets exactly one of the two flags.
- R4: A captured location byte holds the card in bit 7, the bank in bits 6:4, the row in bit 3, zero in bit 2 and the starting quadword in bits 1:0. It is written to the same slot as its log word and in the same cycle.
- R5: A register write replaces the addressed register on the next clock edge. Log bits 7:4 and location bit 2 always read zero. Writing a log word whose bits 1:0 are zero frees that slot.
- R6: An error that finds no free slot is dropped, and the slots are left unchanged. The drop sets the overflow bit (status bit 0). The overflow bit stays set until a reset.
- R7: While rst_warm_n is low, the log words and location bytes keep their values, and writes and error events have no effect on them. The overflow bit reads zero after a warm reset.
- R8: An error capture and a register write that target the same slot in one cycle resolve in favour of the capture. A write that frees a slot makes that slot available to an error arriving in the same cycle.
- R9: When several lanes report errors in one cycle, the errors are placed in ascending chunk-number order. Errors with equal chunk numbers are placed in ascending lane order.
- R10: With SLOTS slots, the register map is as follows. Addresses 0 to SLOTS-1 are the log words. Addresses SLOTS to 2*SLOTS-1 are the location bytes, in bits 7:0 with the upper bits zero. Address 2*SLOTS is the status register, which is read-only. All other addresses read zero. Writes to the status register or to unmapped addresses change nothing.
- R11: reg_rdata shows, in the same cycle, the current value of the register selected by reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous cold reset, active low; clears everything |
| rst_warm_n | input | 1 | Synchronous warm reset, active low; clears only the overflow bit |
| err_valid | input | LANES | Per-lane error strobe |
| err_uncorr | input | LANES | Per-lane flag: 1 = uncorrectable, 0 = correctable |
| err_syndrome | input | 8*LANES | Per-lane syndrome, lane l in bits 8l+7:8l |
| err_chunk | input | 2*LANES | Per-lane chunk index within the burst, lane l in bits 2l+1:2l |
| loc_card | input | 1 | Card holding the failing module |
| loc_bank | input | 3 | Bank within the card |
| loc_row | input | 1 | Row within a double-row module |
| loc_qword | input | 2 | Starting quadword of the critical-order access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | $clog2(2*SLOTS+1) | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
The bench uses the default build: two slots and two lanes. Two lanes allow two errors in one cycle. That exercises the chunk-order rule, the tie-break by lane, and the case where one error of a pair is captured and the other overflows. Two slots fill after two errors, so a third error reaches the drop path. The same is true of a clearing write issued together with an event. A behavioural model, driven by random events, writes and resets, is compared against the read port on every clock.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int SYN_W   = 8;
    localparam int CHUNK_W = 2;
    localparam int LOG_W   = 16;
    localparam int LOC_W   = 8;

    // Bits that software can actually store (reserved bits read zero)
    localparam logic [LOG_W-1:0] LOG_KEEP = 16'hFF0F;
    localparam logic [LOC_W-1:0] LOC_KEEP = 8'hFB;

    typedef struct packed {
        logic       card;
        logic [2:0] bank;
        logic       row;
        logic [1:0] qword;
    } err_loc_t;

    function automatic logic [LOG_W-1:0] make_log(input logic [SYN_W-1:0] syn,
                                                  input logic [CHUNK_W-1:0] chunk,
                                                  input logic unc);
        return {syn, 4'b0000, chunk, unc, ~unc};
    endfunction

    function automatic logic [LOC_W-1:0] make_loc(input err_loc_t l);
        return {l.card, l.bank, l.row, 1'b0, l.qword};
    endfunction

endpackage

// File: rtl/ecc_log_pack.sv
module ecc_log_pack
    import ecc_log_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]         ev_uncorr,
    input  logic [LANES*SYN_W-1:0]   ev_syn,
    input  logic [LANES*CHUNK_W-1:0] ev_chunk,
    output logic [LANES*LOG_W-1:0]   ev_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ev_word[g*LOG_W +: LOG_W] =
            make_log(ev_syn[g*SYN_W +: SYN_W], ev_chunk[g*CHUNK_W +: CHUNK_W], ev_uncorr[g]);
    end

endmodule

// File: rtl/ecc_log_alloc.sv
module ecc_log_alloc #(
    parameter int LANES  = 2,
    parameter int SLOTS  = 2,
    parameter int CHUNKS = 4,
    localparam int CW    = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]    ev_valid,
    input  logic [LANES*CW-1:0] ev_chunk,
    input  logic [SLOTS-1:0]    slot_busy,
    output logic [SLOTS-1:0]    grant,
    output logic [SLOTS*LW-1:0] grant_lane,
    output logic                drop
);

    logic [SLOTS-1:0] avail;
    logic             placed;

    // Visit events in ascending chunk, then ascending lane; each takes the lowest free slot
    always_comb begin
        avail      = ~slot_busy;
        grant      = '0;
        grant_lane = '0;
        drop       = 1'b0;
        placed     = 1'b0;
        for (int c = 0; c < CHUNKS; c++) begin
            for (int l = 0; l < LANES; l++) begin
                if (ev_valid[l] && (ev_chunk[l*CW +: CW] == CW'(c))) begin
                    placed = 1'b0;
                    for (int s = 0; s < SLOTS; s++) begin
                        if (!placed && avail[s]) begin
                            grant[s]               = 1'b1;
                            grant_lane[s*LW +: LW] = LW'(l);
                            avail[s]               = 1'b0;
                            placed                 = 1'b1;
                        end
                    end
                    if (!placed) begin
                        drop = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int LANES = 2,
    localparam int NREG = 2 * SLOTS + 1,
    localparam int AW   = $clog2(NREG),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_cold_n,
    input  logic                     rst_warm_n,
    input  logic [LANES-1:0]         err_valid,
    input  logic [LANES-1:0]         err_uncorr,
    input  logic [LANES*SYN_W-1:0]   err_syndrome,
    input  logic [LANES*CHUNK_W-1:0] err_chunk,
    input  logic                     loc_card,
    input  logic [2:0]               loc_bank,
    input  logic                     loc_row,
    input  logic [1:0]               loc_qword,
    input  logic                     reg_wr_en,
    input  logic [AW-1:0]            reg_addr,
    input  logic [LOG_W-1:0]         reg_wdata,
    output logic [LOG_W-1:0]         reg_rdata
);

    localparam int CHUNKS = 1 << CHUNK_W;
    localparam logic [AW-1:0] STAT_ADDR = AW'(2 * SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0][LOG_W-1:0] log;
        logic [SLOTS-1:0][LOC_W-1:0] loc;
    } sticky_t;

    sticky_t stk_q, stk_d, post_wr;
    logic    ovf_q, ovf_d;

    logic [LANES*LOG_W-1:0] ev_word;
    logic [SLOTS-1:0]       slot_busy;
    logic [SLOTS-1:0]       grant;
    logic [SLOTS*LW-1:0]    grant_lane;
    logic                   drop;
    err_loc_t               cur_loc;
    logic [LOC_W-1:0]       cur_loc_byte;

    // Flattened views for the bound checker
    logic [SLOTS*LOG_W-1:0] log_vis;
    logic [SLOTS*LOC_W-1:0] loc_vis;

    assign cur_loc      = '{card: loc_card, bank: loc_bank, row: loc_row, qword: loc_qword};
    assign cur_loc_byte = make_loc(cur_loc);

    ecc_log_pack #(.LANES(LANES)) u_pack (
        .ev_uncorr (err_uncorr),
        .ev_syn    (err_syndrome),
        .ev_chunk  (err_chunk),
        .ev_word   (ev_word)
    );

    // Software write stage: applied first so that captures override it
    always_comb begin
        post_wr = stk_q;
        if (reg_wr_en) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (reg_addr == AW'(s)) begin
                    post_wr.log[s] = reg_wdata & LOG_KEEP;
                end
                if (reg_addr == AW'(SLOTS + s)) begin
                    post_wr.loc[s] = reg_wdata[LOC_W-1:0] & LOC_KEEP;
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            slot_busy[s] = |post_wr.log[s][1:0];
        end
    end

    ecc_log_alloc #(.LANES(LANES), .SLOTS(SLOTS), .CHUNKS(CHUNKS)) u_alloc (
        .ev_valid   (err_valid),
        .ev_chunk   (err_chunk),
        .slot_busy  (slot_busy),
        .grant      (grant),
        .grant_lane (grant_lane),
        .drop       (drop)
    );

    // Next-state: captures land on top of the write stage
    always_comb begin
        stk_d = post_wr;
        ovf_d = ovf_q | drop;
        for (int s = 0; s < SLOTS; s++) begin
            if (grant[s]) begin
                for (int l = 0; l < LANES; l++) begin
                    if (grant_lane[s*LW +: LW] == LW'(l)) begin
                        stk_d.log[s] = ev_word[l*LOG_W +: LOG_W];
                    end
                end
                stk_d.loc[s] = cur_loc_byte;
            end
        end
    end

    // Sticky storage: cold reset clears, warm reset freezes
    always_ff @(posedge clk) begin
        if (!rst_cold_n) begin
            stk_q <= '0;
        end else if (rst_warm_n) begin
            stk_q <= stk_d;
        end
    end

    // Volatile status: either reset clears
    always_ff @(posedge clk) begin
        if (!rst_cold_n || !rst_warm_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (reg_addr == AW'(s)) begin
                reg_rdata = stk_q.log[s];
            end
            if (reg_addr == AW'(SLOTS + s)) begin
                reg_rdata = {{(LOG_W-LOC_W){1'b0}}, stk_q.loc[s]};
            end
        end
        if (reg_addr == STAT_ADDR) begin
            reg_rdata = {{(LOG_W-1){1'b0}}, ovf_q};
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            log_vis[s*LOG_W +: LOG_W] = stk_q.log[s];
            loc_vis[s*LOC_W +: LOC_W] = stk_q.loc[s];
        end
    end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
    parameter int SLOTS = 2,
    parameter int LANES = 2,
    localparam int AW   = $clog2(2 * SLOTS + 1)
) (
    input logic                 clk,
    input logic                 rst_cold_n,
    input logic                 rst_warm_n,
    input logic [LANES-1:0]     err_valid,
    input logic                 reg_wr_en,
    input logic [AW-1:0]        reg_addr,
    input logic [15:0]          reg_rdata,
    input logic [SLOTS*16-1:0]  log_vis,
    input logic [SLOTS*8-1:0]   loc_vis,
    input logic                 ovf_q
);

    logic all_busy;
    always_comb begin
        all_busy = 1'b1;
        for (int s = 0; s < SLOTS; s++) begin
            all_busy = all_busy & (|log_vis[s*16 +: 2]);
        end
    end

    p_cold_clear_r1: assert property (@(posedge clk)
        !rst_cold_n |=> (log_vis == '0 && loc_vis == '0 && !ovf_q));

    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (rst_warm_n && !reg_wr_en && log_vis[1:0] == 2'b00 && |err_valid)
        |=> (log_vis[1:0] != 2'b00));

    p_one_flag_r3: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (rst_warm_n && !reg_wr_en && log_vis[1:0] == 2'b00 && |err_valid)
        |=> ($countones(log_vis[1:0]) == 1));

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_cold_n)
            (log_vis[g*16+4 +: 4] == 4'b0000 && loc_vis[g*8+2] == 1'b0));
    end

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (rst_warm_n && !reg_wr_en && all_busy && |err_valid)
        |=> (ovf_q && $stable(log_vis) && $stable(loc_vis)));

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (ovf_q && rst_warm_n) |=> ovf_q);

    p_warm_hold_r7: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !rst_warm_n |=> ($stable(log_vis) && $stable(loc_vis) && !ovf_q));

    p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (reg_addr == AW'(2 * SLOTS)) |-> (reg_rdata == {15'b0, ovf_q}));

endmodule

bind ecc_err_log ecc_err_log_chk #(.SLOTS(SLOTS), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .rst_warm_n (rst_warm_n),
    .err_valid  (err_valid),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .log_vis    (log_vis),
    .loc_vis    (loc_vis),
    .ovf_q      (ovf_q)
);

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;

    localparam int NS = 2;
    localparam int NL = 2;
    localparam int AW = $clog2(2 * NS + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_cold_n = 1'b0;
    logic           rst_warm_n = 1'b1;
    logic [NL-1:0]  ev_v;
    logic [NL-1:0]  ev_u;
    logic [7:0]     ev_syn [NL];
    logic [1:0]     ev_ch  [NL];
    logic           l_card;
    logic [2:0]     l_bank;
    logic           l_row;
    logic [1:0]     l_qw;
    logic           wr_en;
    logic [AW-1:0]  addr;
    logic [15:0]    wdata;
    logic [15:0]    rdata;
    logic [NL*8-1:0] syn_flat;
    logic [NL*2-1:0] ch_flat;

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            syn_flat[l*8 +: 8] = ev_syn[l];
            ch_flat[l*2 +: 2]  = ev_ch[l];
        end
    end

    ecc_err_log #(.SLOTS(NS), .LANES(NL)) u_ecc_err_log (
        .clk          (clk),
        .rst_cold_n   (rst_cold_n),
        .rst_warm_n   (rst_warm_n),
        .err_valid    (ev_v),
        .err_uncorr   (ev_u),
        .err_syndrome (syn_flat),
        .err_chunk    (ch_flat),
        .loc_card     (l_card),
        .loc_bank     (l_bank),
        .loc_row      (l_row),
        .loc_qword    (l_qw),
        .reg_wr_en    (wr_en),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference model
    int m_log [NS];
    int m_loc [NS];
    int m_ovf;

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_log[s] = 0;
            m_loc[s] = 0;
        end
        m_ovf = 0;
    end

    function automatic int model_read(input int a);
        if (a < NS) return m_log[a];
        if (a < 2 * NS) return m_loc[a - NS];
        if (a == 2 * NS) return m_ovf;
        return 0;
    endfunction

    function automatic string tag_of(input int a);
        if (a < NS) return "R3";
        if (a < 2 * NS) return "R4";
        if (a == 2 * NS) return "R6";
        return "R10";
    endfunction

    always @(posedge clk) begin
        int q[$];
        if (!rst_cold_n) begin
            for (int s = 0; s < NS; s++) begin
                m_log[s] = 0;
                m_loc[s] = 0;
            end
            m_ovf = 0;
        end else if (!rst_warm_n) begin
            m_ovf = 0;
        end else begin
            if (wr_en) begin
                if (int'(addr) < NS) m_log[addr] = int'(wdata) & 'hFF0F;
                else if (int'(addr) < 2 * NS) m_loc[int'(addr) - NS] = int'(wdata) & 'hFB;
            end
            for (int c = 0; c < 4; c++)
                for (int l = 0; l < NL; l++)
                    if (ev_v[l] && int'(ev_ch[l]) == c) q.push_back(l);
            while (q.size() > 0) begin
                int l;
                int slot;
                l = q.pop_front();
                slot = -1;
                for (int s = 0; s < NS; s++)
                    if (slot < 0 && (m_log[s] & 3) == 0) slot = s;
                if (slot >= 0) begin
                    m_log[slot] = (int'(ev_syn[l]) << 8) | (int'(ev_ch[l]) << 2) | (ev_u[l] ? 2 : 1);
                    m_loc[slot] = (int'(l_card) << 7) | (int'(l_bank) << 4) | (int'(l_row) << 3) | int'(l_qw);
                end else begin
                    m_ovf = 1;
                end
            end
        end
    end

    // Per-clock comparison of the read port against the model (R11)
    always @(negedge clk) begin
        #1;
        if (!done) begin
            int exp_v;
            exp_v = model_read(int'(addr));
            checks++;
            if (rdata !== 16'(exp_v)) begin
                errors++;
                $display("FAIL %s/R11 model compare addr %0d: actual %h expected %h",
                         tag_of(int'(addr)), addr, rdata, 16'(exp_v));
            end
        end
    end

    task automatic idle();
        ev_v   = '0;
        ev_u   = '0;
        for (int l = 0; l < NL; l++) begin
            ev_syn[l] = '0;
            ev_ch[l]  = '0;
        end
        l_card = 0; l_bank = 0; l_row = 0; l_qw = 0;
        wr_en  = 0;
        wdata  = '0;
    endtask

    task automatic set_ev(input int l, input logic [7:0] syn, input logic [1:0] ch, input logic unc);
        ev_v[l]   = 1'b1;
        ev_u[l]   = unc;
        ev_syn[l] = syn;
        ev_ch[l]  = ch;
    endtask

    task automatic set_loc(input logic c, input logic [2:0] b, input logic r, input logic [1:0] q);
        l_card = c; l_bank = b; l_row = r; l_qw = q;
    endtask

    task automatic fire();
        @(posedge clk);
        #1 idle();
    endtask

    task automatic chk(input int a, input logic [15:0] exp_v, input string req);
        @(negedge clk);
        addr = AW'(a);
        #1;
        checks++;
        if (rdata !== exp_v) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, exp_v);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        addr = '0;
        repeat (3) @(negedge clk);
        rst_cold_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 2 * NS; a++) chk(a, 16'h0000, "R1");

        // R2 R3 R4: first correctable error into slot 0
        @(negedge clk);
        set_ev(0, 8'hA5, 2'd2, 1'b0);
        set_loc(1'b1, 3'd5, 1'b1, 2'd2);
        fire();
        chk(0, 16'hA509, "R2/R3");
        chk(NS + 0, 16'h00DA, "R4");
        chk(1, 16'h0000, "R2");

        // R2 R3 R4: second (uncorrectable) error into slot 1
        @(negedge clk);
        set_ev(1, 8'h3C, 2'd1, 1'b1);
        set_loc(1'b0, 3'd3, 1'b0, 2'd1);
        fire();
        chk(1, 16'h3C06, "R2/R3");
        chk(NS + 1, 16'h0031, "R4");

        // R6: third error is dropped, overflow set
        @(negedge clk);
        set_ev(0, 8'h11, 2'd0, 1'b0);
        set_loc(1'b1, 3'd7, 1'b1, 2'd3);
        fire();
        chk(0, 16'hA509, "R6");
        chk(NS + 0, 16'h00DA, "R6");
        chk(2 * NS, 16'h0001, "R6");

        // R7: warm reset with a write and an event present
        @(negedge clk);
        rst_warm_n = 1'b0;
        set_ev(0, 8'h99, 2'd3, 1'b1);
        wr_en = 1'b1; addr = AW'(0); wdata = 16'h0000;
        fire();
        rst_warm_n = 1'b1;
        chk(2 * NS, 16'h0000, "R7");
        chk(0, 16'hA509, "R7");
        chk(1, 16'h3C06, "R7");

        // R5: write reserved bits and clear flags of slot 0
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(0); wdata = 16'hFFF0;
        fire();
        chk(0, 16'hFF00, "R5");

        // R9: two lanes, lower chunk captured first, other overflows
        @(negedge clk);
        set_ev(0, 8'h77, 2'd3, 1'b0);
        set_ev(1, 8'h22, 2'd0, 1'b1);
        set_loc(1'b0, 3'd7, 1'b0, 2'd3);
        fire();
        chk(0, 16'h2202, "R9");
        chk(NS + 0, 16'h0073, "R9");
        chk(2 * NS, 16'h0001, "R9/R6");

        // R8: freeing write to slot 1 plus an event in the same cycle
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(1); wdata = 16'h0000;
        set_ev(0, 8'h5A, 2'd1, 1'b0);
        set_loc(1'b1, 3'd0, 1'b0, 2'd0);
        fire();
        chk(1, 16'h5A05, "R8");
        chk(NS + 1, 16'h0080, "R8");

        // R5 R10: location write mask, status read-only, unmapped reads zero
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(NS); wdata = 16'hFFFF;
        fire();
        chk(NS, 16'h00FB, "R5");
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(2 * NS); wdata = 16'h0000;
        fire();
        chk(2 * NS, 16'h0001, "R10");
        for (int a = 2 * NS + 1; a < (1 << AW); a++) chk(a, 16'h0000, "R10");

        // R1: cold reset clears sticky state
        @(negedge clk);
        rst_cold_n = 1'b0;
        fire();
        rst_cold_n = 1'b1;
        for (int a = 0; a <= 2 * NS; a++) chk(a, 16'h0000, "R1");

        // R9: equal chunk numbers, lane order decides
        @(negedge clk);
        set_ev(0, 8'h01, 2'd2, 1'b0);
        set_ev(1, 8'h02, 2'd2, 1'b1);
        fire();
        chk(0, 16'h0109, "R9");
        chk(1, 16'h020A, "R9");

        // Random phase: model compare every clock (R2..R11)
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            idle();
            for (int l = 0; l < NL; l++) begin
                if ($urandom_range(3) == 0)
                    set_ev(l, 8'($urandom), 2'($urandom), 1'($urandom));
            end
            set_loc(1'($urandom), 3'($urandom), 1'($urandom), 2'($urandom));
            addr = AW'($urandom);
            if ($urandom_range(4) == 0) begin
                wr_en = 1'b1;
                wdata = 16'($urandom);
                if ($urandom_range(1) == 0) wdata[1:0] = 2'b00;
            end
            rst_warm_n = ($urandom_range(40) != 0);
            rst_cold_n = ($urandom_range(600) != 0);
        end
        @(negedge clk);
        idle();
        rst_warm_n = 1'b1;
        rst_cold_n = 1'b1;
        repeat (2) @(negedge clk);

        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule